// File: doc/BRIEF.md
# Pulse-Width Ripple Meter

The block measures how long an input pulse stays high. It counts rising edges of a fast sample clock while the pulse is high. Speed matters more than a synchronous count, so the counter is a ripple chain. A front-end gate and toggle flip-flop run on the fast clock. Every later stage is a small counter clocked by the falling top bit of the stage before it. Carries therefore travel through the chain without any shared counter clock.

A controller in a slower housekeeping clock domain runs each measurement. It synchronizes the pulse with two flip-flops. It opens the measurement window by releasing the asynchronous clear of the front-end gate, and closes it again once the pulse has ended. It then waits a fixed number of housekeeping cycles so the ripple can settle. Next it copies the count and an overflow flag into a result register and flags the result as valid for one cycle. Finally it clears the whole chain and returns to idle for the next measurement.

The held result is read through a bus that is driven only on request and is high impedance otherwise.

Top module: `pulse_width_meter`

## Requirements
- R1: After a measurement, the low COUNT_W bits of `count_bus` equal the number of fast-clock rising edges at which `pulse_in` was sampled high. This assumes `pulse_in` rose while the meter was armed.
- R2: The count wraps modulo 2^COUNT_W. Bit COUNT_W of `count_bus` is a sticky overflow flag, set when the number of counted edges reaches 2^COUNT_W or more.
- R3: `result_valid` is high for exactly one housekeeping cycle per completed measurement, and the latched result is already on the bus in that cycle.
- R4: Between two measurements, the latched count and overflow flag stay unchanged. They can only change in a cycle in which `result_valid` is high.
- R5: While `arm_en` is low, the meter does not arm. Pulses arriving then produce no `result_valid` and leave the held result unchanged.
- R6: Once a result has been latched, every ripple stage and the overflow flag are cleared. Each measurement therefore counts only its own pulse.
- R7: `count_bus` is driven, and `bus_oe` is high, only when `read_en` is high and at least one result has been latched since reset. Otherwise `count_bus` is high impedance and `bus_oe` is low.
- R8: While `rst_n` is low and just after it is released, `result_valid` and `bus_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast sample clock; drives only the front-end stage |
| clk_hk | input | 1 | Housekeeping clock for the controller |
| rst_n | input | 1 | Active-low reset, synchronous to clk_hk |
| arm_en | input | 1 | Allows the controller to arm a new measurement |
| pulse_in | input | 1 | Pulse to be measured, changing away from clk_fast rising edges |
| read_en | input | 1 | Request to drive the held result onto count_bus |
| result_valid | output | 1 | One-cycle strobe when a new result has been latched |
| bus_oe | output | 1 | High while count_bus is driven |
| count_bus | output | COUNT_W+1 | Overflow flag in the top bit, count below it; high impedance when not driven |

## Verification
The assertions assume that `pulse_in` is low when the meter arms. They also assume it stays high for at least two housekeeping periods, so the synchronizer sees it, and stays low long enough that the gate is already empty when the window closes. The stimulus meets these assumptions: it changes the pulse only on falling edges of the fast clock, and every pulse is at least ten fast cycles long, which is two housekeeping periods. It also waits several housekeeping cycles after each result before driving the next pulse. Under these conditions the count is exact, so the bench can compare it arithmetically with the number of edges it drove.

// File: rtl/pwm_pkg.sv
// Shared types for the pulse-width meter.
// Assumes: nothing beyond IEEE 1800-2017.
package pwm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_COUNT  = 3'd2,
        ST_SETTLE = 3'd3,
        ST_LATCH  = 3'd4,
        ST_CLEAR  = 3'd5
    } pwm_state_e;
endpackage

// File: rtl/pwm_sync2.sv
// Two-flop synchronizer bringing the pulse into the housekeeping domain.
// Assumes: the input is asynchronous to clk and is a level, not a strobe.
module pwm_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic meta_q, sync_q;

    // Two-stage capture with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/pwm_ripple_stage.sv
// One ripple stage: a W-bit binary counter that advances when its clock input
// falls (the top bit of the preceding stage wrapping to zero).
// Assumes: clr_n is a glitch-free registered level; the asynchronous clear is
// intentional because this clock domain has no reset of its own.
module pwm_ripple_stage #(
    parameter int W = 2
) (
    input  logic         tick_i,
    input  logic         clr_n,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;

    // Advance on the falling carry, clear asynchronously between runs.
    always_ff @(negedge tick_i or negedge clr_n) begin
        if (!clr_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + W'(1);
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_ripple_chain.sv
// Ripple counter of COUNT_W bits plus a sticky overflow flop.
// The front end is a gate flop sampling the pulse on clk_fast, with its
// clear driven by the controller's window, followed by the toggle flop
// (bit 0). Later stages are pwm_ripple_stage instances of two bits each
// (one bit for the last stage when widths do not divide evenly), each
// clocked by the top bit of the stage before.
// Assumes: the outputs are read only after the ripple has settled.
module pwm_ripple_chain #(
    parameter int COUNT_W = 16
) (
    input  logic               clk_fast,
    input  logic               pulse_i,
    input  logic               window_i,
    input  logic               clr_n,
    output logic [COUNT_W-1:0] count_o,
    output logic               ovf_o
);
    localparam int NSTG = COUNT_W / 2;

    logic            gate_q;
    logic            tog_q;
    logic [NSTG:0]   carry;
    logic            ovf_q;

    // Front-end gate: held clear outside the measurement window.
    always_ff @(posedge clk_fast or negedge window_i) begin
        if (!window_i) gate_q <= 1'b0;
        else           gate_q <= pulse_i;
    end

    // Front-end toggle flop: bit 0 of the count.
    always_ff @(posedge clk_fast or negedge clr_n) begin
        if (!clr_n)      tog_q <= 1'b0;
        else if (gate_q) tog_q <= ~tog_q;
    end

    assign carry[0]   = tog_q;
    assign count_o[0] = tog_q;

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        localparam int LO = 1 + 2 * s;
        localparam int W  = (COUNT_W - LO >= 2) ? 2 : 1;
        logic [W-1:0] bits;
        pwm_ripple_stage #(.W(W)) u_stage (
            .tick_i (carry[s]),
            .clr_n  (clr_n),
            .cnt_o  (bits)
        );
        assign count_o[LO +: W] = bits;
        assign carry[s+1]       = bits[W-1];
    end

    // Sticky overflow: set when the top bit wraps.
    always_ff @(negedge carry[NSTG] or negedge clr_n) begin
        if (!clr_n) ovf_q <= 1'b0;
        else        ovf_q <= 1'b1;
    end

    assign ovf_o = ovf_q;
endmodule

// File: rtl/pwm_ctrl.sv
// Housekeeping controller: IDLE -> ARMED -> COUNT -> SETTLE -> LATCH ->
// CLEAR -> IDLE. It drives the window and the chain clear from registers,
// captures the settled count and produces the valid strobe.
// Assumes: pulse_s is already synchronized; the chain is stable once
// SETTLE_CYC cycles have passed since the window closed.
module pwm_ctrl
    import pwm_pkg::*;
#(
    parameter int COUNT_W    = 16,
    parameter int SETTLE_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm_en,
    input  logic               pulse_s,
    input  logic [COUNT_W-1:0] chain_cnt,
    input  logic               chain_ovf,
    output logic               window_o,
    output logic               clr_n_o,
    output logic               valid_o,
    output logic               have_o,
    output logic [COUNT_W-1:0] res_cnt_o,
    output logic               res_ovf_o
);
    localparam int SW = $clog2(SETTLE_CYC + 1);

    pwm_state_e   state_q, state_d;
    logic [SW-1:0] settle_q;
    logic          settle_done;
    logic          window_q, clr_n_q, have_q, res_ovf_q;
    logic [COUNT_W-1:0] res_cnt_q;

    assign settle_done = (settle_q == SW'(SETTLE_CYC - 1));

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (arm_en) state_d = ST_ARMED;
            ST_ARMED:  if (!arm_en) state_d = ST_IDLE;
                       else if (pulse_s) state_d = ST_COUNT;
            ST_COUNT:  if (!pulse_s) state_d = ST_SETTLE;
            ST_SETTLE: if (settle_done) state_d = ST_LATCH;
            ST_LATCH:  state_d = ST_CLEAR;
            ST_CLEAR:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State, settle timer and registered window/clear controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            settle_q <= '0;
            window_q <= 1'b0;
            clr_n_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            settle_q <= (state_q == ST_SETTLE) ? settle_q + SW'(1) : '0;
            window_q <= (state_d == ST_ARMED) || (state_d == ST_COUNT);
            clr_n_q  <= (state_d != ST_CLEAR);
        end
    end

    // Result capture when the settle time has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_cnt_q <= '0;
            res_ovf_q <= 1'b0;
            have_q    <= 1'b0;
        end else if (state_q == ST_SETTLE && settle_done) begin
            res_cnt_q <= chain_cnt;
            res_ovf_q <= chain_ovf;
            have_q    <= 1'b1;
        end
    end

    assign window_o  = window_q;
    assign clr_n_o   = clr_n_q;
    assign valid_o   = (state_q == ST_LATCH);
    assign have_o    = have_q;
    assign res_cnt_o = res_cnt_q;
    assign res_ovf_o = res_ovf_q;
endmodule

// File: rtl/pulse_width_meter.sv
// Top of the pulse-width meter: synchronizer, controller, ripple chain and
// the high-impedance result bus.
// Assumes: pulse_in is low when arming and lasts at least two clk_hk periods.
module pulse_width_meter #(
    parameter int COUNT_W    = 16,
    parameter int SETTLE_CYC = 4
) (
    input  logic               clk_fast,
    input  logic               clk_hk,
    input  logic               rst_n,
    input  logic               arm_en,
    input  logic               pulse_in,
    input  logic               read_en,
    output logic               result_valid,
    output logic               bus_oe,
    output logic [COUNT_W:0]   count_bus
);
    logic               pulse_s;
    logic               window, chain_clr_n, have_res, res_ovf, chain_ovf;
    logic [COUNT_W-1:0] res_cnt, chain_cnt;

    pwm_sync2 u_sync (
        .clk   (clk_hk),
        .rst_n (rst_n),
        .d_i   (pulse_in),
        .q_o   (pulse_s)
    );

    pwm_ctrl #(.COUNT_W(COUNT_W), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
        .clk       (clk_hk),
        .rst_n     (rst_n),
        .arm_en    (arm_en),
        .pulse_s   (pulse_s),
        .chain_cnt (chain_cnt),
        .chain_ovf (chain_ovf),
        .window_o  (window),
        .clr_n_o   (chain_clr_n),
        .valid_o   (result_valid),
        .have_o    (have_res),
        .res_cnt_o (res_cnt),
        .res_ovf_o (res_ovf)
    );

    pwm_ripple_chain #(.COUNT_W(COUNT_W)) u_chain (
        .clk_fast (clk_fast),
        .pulse_i  (pulse_in),
        .window_i (window),
        .clr_n    (chain_clr_n),
        .count_o  (chain_cnt),
        .ovf_o    (chain_ovf)
    );

    // Bus driver: result only on request and once a result exists.
    assign bus_oe    = read_en && have_res;
    assign count_bus = bus_oe ? {res_ovf, res_cnt} : 'z;
endmodule

// File: rtl/pulse_width_meter_checker.sv
// Checker for pulse_width_meter, bound to the top by the statement below.
// Assumes: it samples on clk_hk; the chain is stable outside the window.
module pulse_width_meter_checker #(
    parameter int COUNT_W = 16
) (
    input logic               clk_hk,
    input logic               rst_n,
    input logic               read_en,
    input logic               result_valid,
    input logic               bus_oe,
    input logic [COUNT_W-1:0] res_cnt,
    input logic               res_ovf,
    input logic [COUNT_W-1:0] chain_cnt,
    input logic               chain_ovf
);
    AST_VALID_SINGLE: assert property (@(posedge clk_hk) disable iff (!rst_n)
        result_valid |=> !result_valid);                                   // R3
    AST_RESULT_HOLD: assert property (@(posedge clk_hk) disable iff (!rst_n)
        !$stable({res_ovf, res_cnt}) |-> result_valid);                    // R4
    AST_CHAIN_CLEARED: assert property (@(posedge clk_hk) disable iff (!rst_n)
        result_valid |=> (chain_cnt == '0 && !chain_ovf));                 // R6
    AST_BUS_QUIET: assert property (@(posedge clk_hk) disable iff (!rst_n)
        !read_en |-> !bus_oe);                                             // R7
endmodule

bind pulse_width_meter pulse_width_meter_checker #(.COUNT_W(COUNT_W)) u_chk (
    .clk_hk       (clk_hk),
    .rst_n        (rst_n),
    .read_en      (read_en),
    .result_valid (result_valid),
    .bus_oe       (bus_oe),
    .res_cnt      (res_cnt),
    .res_ovf      (res_ovf),
    .chain_cnt    (chain_cnt),
    .chain_ovf    (chain_ovf)
);

// File: tb/pulse_width_meter_test.sv
// Bench: drives pulses of known length and compares the result with the
// number of fast rising edges it drove, wrapped to COUNT_W bits.
module pulse_width_meter_test;
    localparam int FAST_PERIOD = 2;
    localparam int HK_PERIOD   = 10;
    localparam int CW          = 16;

    logic clk_fast = 1'b0, clk_hk = 1'b0;
    logic rst_n = 1'b0, arm_en = 1'b0, pulse_in = 1'b0, read_en = 1'b0;
    logic result_valid, bus_oe;
    wire  [CW:0] count_bus;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #(FAST_PERIOD/2) clk_fast = ~clk_fast;
    always #(HK_PERIOD/2)   clk_hk   = ~clk_hk;

    pulse_width_meter #(.COUNT_W(CW), .SETTLE_CYC(4)) uut (
        .clk_fast (clk_fast), .clk_hk (clk_hk), .rst_n (rst_n),
        .arm_en (arm_en), .pulse_in (pulse_in), .read_en (read_en),
        .result_valid (result_valid), .bus_oe (bus_oe), .count_bus (count_bus)
    );

    task automatic check(input bit ok, input string req, input string act, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Pulse held for n fast rising edges, changed on falling edges.
    task automatic drive_pulse(input int n);
        @(negedge clk_fast);
        pulse_in = 1'b1;
        repeat (n) @(negedge clk_fast);
        pulse_in = 1'b0;
    endtask

    task automatic wait_valid(input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit && !seen; i++) begin
            @(negedge clk_hk);
            if (result_valid) seen = 1'b1;
        end
    endtask

    // One measurement: pulse of n edges, then result and strobe checks.
    task automatic measure(input int n);
        bit seen;
        logic [CW:0] exp;
        exp = {(n >= (1 << CW)) ? 1'b1 : 1'b0, CW'(n)};
        drive_pulse(n);
        wait_valid(100, seen);
        check(seen, "R3", $sformatf("valid=%0b", seen), "valid=1");
        check(count_bus === exp, (n >= (1 << CW)) ? "R2" : "R1",
              $sformatf("%h", count_bus), $sformatf("%h", exp));
        @(negedge clk_hk);
        check(result_valid === 1'b0, "R3", $sformatf("%b", result_valid), "0");
        repeat (5) @(negedge clk_hk);
        check(count_bus === exp, "R4", $sformatf("%h", count_bus), $sformatf("%h", exp));
    endtask

    initial begin
        #(FAST_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        bit seen;
        logic [CW:0] held;
        read_en = 1'b1;
        repeat (3) @(negedge clk_hk);
        check(result_valid === 1'b0 && bus_oe === 1'b0, "R8",
              $sformatf("v=%b oe=%b", result_valid, bus_oe), "v=0 oe=0");
        rst_n = 1'b1;
        @(negedge clk_hk);
        check(result_valid === 1'b0 && bus_oe === 1'b0, "R8",
              $sformatf("v=%b oe=%b", result_valid, bus_oe), "v=0 oe=0");
        check(count_bus === 'z, "R7", $sformatf("%h", count_bus), "z (no result yet)");
        arm_en = 1'b1;
        repeat (4) @(negedge clk_hk);

        // Sweep of pulse lengths; each run also proves the chain was cleared (R6).
        for (int n = 10; n <= 40; n++) measure(n);
        measure(255);
        measure(256);
        measure(1023);

        // Bus released when read is off (R7).
        read_en = 1'b0;
        @(negedge clk_hk);
        check(count_bus === 'z && bus_oe === 1'b0, "R7",
              $sformatf("%h oe=%b", count_bus, bus_oe), "z oe=0");
        read_en = 1'b1;
        @(negedge clk_hk);
        held = count_bus;

        // Disarmed: pulse ignored, result held (R5).
        arm_en = 1'b0;
        repeat (4) @(negedge clk_hk);
        drive_pulse(30);
        wait_valid(60, seen);
        check(!seen, "R5", $sformatf("valid seen=%0b", seen), "0");
        check(count_bus === held, "R5", $sformatf("%h", count_bus), $sformatf("%h", held));
        arm_en = 1'b1;
        repeat (4) @(negedge clk_hk);
        measure(12);                      // R6: earlier ignored pulse not added

        // Boundaries of the 16-bit range and overflow (R2).
        measure(65535);
        measure(65536 + 5);
        measure(11);                      // R6: overflow flag cleared again
        finish_run();
    end
endmodule